// File: doc/BRIEF.md
# Multi-Port Register Memory

A word-addressed storage array built from flip-flops, with a configurable number of read ports and write ports that all work in the same cycle. The array holds `WORDS` words of `WIDTH` bits, addressed through `ABITS`-bit addresses. Every port has a fixed slice of a wide concatenated bus. Port `i` uses address bits `[i*ABITS +: ABITS]` and data or mask bits `[i*WIDTH +: WIDTH]`.

Each read port is set up at elaboration time by three parameter bits. `RD_CLKED` picks a combinational port or a registered port. `RD_POSEDGE` picks the capture edge of a registered port. `RD_TRANSP` decides whether a registered port that captures on the write edge sees that cycle's writes. Write ports update the array on the rising edge of `clk`. A write port changes only the bits its mask enables. A bit that several ports write in the same cycle goes to the port with the highest `WR_PRIO` value. `INIT` gives the contents that the array loads while reset is active.

A typical use is a small multi-ported register file or lookup store in a datapath, where ports with different timing needs share one set of words.

Top module: `regmem_multiport`

## Requirements
- R1: While `rst` is high at a capture edge, every registered read port output is cleared to 0. This applies to both rising-edge and falling-edge ports.
- R2: While `rst` is high at a rising edge, word k is loaded from `INIT[k*WIDTH +: WIDTH]`, and any write in that cycle is dropped.
- R3: A read port whose `RD_CLKED` bit is 0 is combinational. It shows the word at its address in the same cycle, and it shows a write from the rising edge at which that write lands.
- R4: A registered read port captures on the rising edge of `clk` when its `RD_POSEDGE` bit is 1 and on the falling edge when the bit is 0. It captures only while its `rd_en` bit is 1, and otherwise holds its value.
- R5: A rising-edge registered port with `RD_TRANSP` bit 1 that reads the address being written returns the word as it is after the write. With `RD_TRANSP` bit 0 it returns the word as it was before. A falling-edge port always returns the stored word.
- R6: Write port p changes bit b of its word only when `wr_en[p*WIDTH+b]` is 1. All other bits keep their values.
- R7: When several ports write the same bit of the same word in one cycle, the port with the larger `WR_PRIO[p*PW +: PW]` wins. On equal priority the port with the higher index wins. Bits that only one port enables take that port's data.
- R8: Reading an address at or above `WORDS` returns 0. A write to such an address changes nothing.
- R9: Ports are packed by index: read port i uses `rd_en[i]`, `rd_addr[i*ABITS +: ABITS]` and `rd_data[i*WIDTH +: WIDTH]`. Write port p uses `wr_addr[p*ABITS +: ABITS]`, `wr_data[p*WIDTH +: WIDTH]` and `wr_en[p*WIDTH +: WIDTH]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports; write edge is rising |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | NRD | Capture enable, one bit per read port |
| rd_addr | input | NRD*ABITS | Concatenated read addresses |
| rd_data | output | NRD*WIDTH | Concatenated read data |
| wr_en | input | NWR*WIDTH | Concatenated per-bit write masks |
| wr_addr | input | NWR*ABITS | Concatenated write addresses |
| wr_data | input | NWR*WIDTH | Concatenated write data |

## Verification
The hardest case to reach from the ports is three write ports hitting one word with overlapping partial masks, in the same cycle that both a transparent and a non-transparent port read that word. Only then are the priority order, the tie rule and the merge of uncontested bits all visible together, along with the old-versus-new choice. The stimulus makes this common. Write addresses are steered to one word half the time, and a read port is often pointed at the address of a write port. A directed collision adds a fixed mask pattern whose winner is known for each bit. Falling-edge capture and out-of-range addresses are covered by the same sweep, because all eight addresses of the three-bit bus are used against a six-word array.

// File: rtl/regmem_pkg.sv
package regmem_pkg;

  // True when port a takes a contested bit away from port b.
  function automatic logic outranks(input int unsigned prio_a, input int unsigned idx_a,
                                    input int unsigned prio_b, input int unsigned idx_b);
    return (prio_a > prio_b) || ((prio_a == prio_b) && (idx_a > idx_b));
  endfunction

  function automatic logic addr_in_range(input int unsigned addr, input int unsigned words);
    return addr < words;
  endfunction

endpackage

// File: rtl/regmem_wr_arbiter.sv
module regmem_wr_arbiter #(
  parameter int unsigned NWR   = 3,
  parameter int unsigned WIDTH = 4,
  parameter int unsigned ABITS = 3,
  parameter int unsigned WORDS = 6,
  parameter int unsigned PW    = 2,
  parameter logic [NWR*PW-1:0] PRIO = '0
) (
  input  logic [NWR*ABITS-1:0] wr_addr,
  input  logic [NWR*WIDTH-1:0] wr_mask,
  output logic [NWR*WIDTH-1:0] eff_mask
);
  import regmem_pkg::*;

  for (genvar p = 0; p < NWR; p++) begin : g_port
    logic [ABITS-1:0] addr_p;
    logic [WIDTH-1:0] keep;
    assign addr_p = wr_addr[p*ABITS +: ABITS];

    always_comb begin
      keep = addr_in_range(32'(addr_p), WORDS) ? wr_mask[p*WIDTH +: WIDTH] : '0;
      for (int unsigned q = 0; q < NWR; q++) begin
        if ((q != p) && (wr_addr[q*ABITS +: ABITS] == addr_p) &&
            outranks(32'(PRIO[q*PW +: PW]), q, 32'(PRIO[p*PW +: PW]), p)) begin
          keep = keep & ~wr_mask[q*WIDTH +: WIDTH];
        end
      end
    end

    assign eff_mask[p*WIDTH +: WIDTH] = keep;
  end

endmodule

// File: rtl/regmem_store.sv
module regmem_store #(
  parameter int unsigned WORDS = 6,
  parameter int unsigned ABITS = 3,
  parameter int unsigned WIDTH = 4,
  parameter int unsigned NRD   = 4,
  parameter int unsigned NWR   = 3,
  parameter logic [WORDS*WIDTH-1:0] INIT = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NWR*ABITS-1:0] wr_addr,
  input  logic [NWR*WIDTH-1:0] wr_data,
  input  logic [NWR*WIDTH-1:0] eff_mask,
  input  logic [NRD*ABITS-1:0] rd_addr,
  output logic [NRD*WIDTH-1:0] rd_now,
  output logic [NRD*WIDTH-1:0] rd_next
);

  logic [WIDTH-1:0] mem_q [WORDS];
  logic [WIDTH-1:0] mem_d [WORDS];

  // Next state of every word; masks arrive already disjoint per bit.
  always_comb begin
    for (int unsigned w = 0; w < WORDS; w++) begin
      mem_d[w] = mem_q[w];
      for (int unsigned p = 0; p < NWR; p++) begin
        if (32'(wr_addr[p*ABITS +: ABITS]) == w) begin
          mem_d[w] = (mem_d[w] & ~eff_mask[p*WIDTH +: WIDTH]) |
                     (wr_data[p*WIDTH +: WIDTH] & eff_mask[p*WIDTH +: WIDTH]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int unsigned w = 0; w < WORDS; w++) begin
      if (rst) mem_q[w] <= INIT[w*WIDTH +: WIDTH];
      else     mem_q[w] <= mem_d[w];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [WIDTH-1:0] now_w, next_w;
    always_comb begin
      now_w  = '0;
      next_w = '0;
      for (int unsigned w = 0; w < WORDS; w++) begin
        if (32'(rd_addr[r*ABITS +: ABITS]) == w) begin
          now_w  = mem_q[w];
          next_w = mem_d[w];
        end
      end
    end
    assign rd_now[r*WIDTH +: WIDTH]  = now_w;
    assign rd_next[r*WIDTH +: WIDTH] = next_w;
  end

endmodule

// File: rtl/regmem_rd_port.sv
module regmem_rd_port #(
  parameter int unsigned WIDTH  = 4,
  parameter bit          CLKED  = 1'b1,
  parameter bit          RISE   = 1'b1,
  parameter bit          TRANSP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] word_now,
  input  logic [WIDTH-1:0] word_next,
  output logic [WIDTH-1:0] data
);

  logic unused_in;
  assign unused_in = ^{clk, rst, en, word_now, word_next};

  if (!CLKED) begin : g_async
    assign data = word_now;
  end else if (RISE) begin : g_rise
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (en) q <= TRANSP ? word_next : word_now;
    end
    assign data = q;
  end else begin : g_fall
    logic [WIDTH-1:0] q;
    always_ff @(negedge clk) begin
      if (rst)     q <= '0;
      else if (en) q <= word_now;
    end
    assign data = q;
  end

endmodule

// File: rtl/regmem_multiport.sv
module regmem_multiport #(
  parameter int unsigned WORDS = 6,
  parameter int unsigned ABITS = 3,
  parameter int unsigned WIDTH = 4,
  parameter int unsigned NRD   = 4,
  parameter int unsigned NWR   = 3,
  parameter int unsigned PW    = 2,
  parameter logic [NRD-1:0]         RD_CLKED   = 4'b1110,
  parameter logic [NRD-1:0]         RD_POSEDGE = 4'b0111,
  parameter logic [NRD-1:0]         RD_TRANSP  = 4'b0010,
  parameter logic [NWR*PW-1:0]      WR_PRIO    = {2'd1, 2'd1, 2'd2},
  parameter logic [WORDS*WIDTH-1:0] INIT       = 24'hEDCBA9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NRD-1:0]       rd_en,
  input  logic [NRD*ABITS-1:0] rd_addr,
  output logic [NRD*WIDTH-1:0] rd_data,
  input  logic [NWR*WIDTH-1:0] wr_en,
  input  logic [NWR*ABITS-1:0] wr_addr,
  input  logic [NWR*WIDTH-1:0] wr_data
);

  localparam int unsigned RD_BUS = NRD * WIDTH;
  localparam int unsigned WR_BUS = NWR * WIDTH;

  logic [WR_BUS-1:0] wr_eff;
  logic [RD_BUS-1:0] rd_raw;
  logic [RD_BUS-1:0] rd_fwd;

  regmem_wr_arbiter #(
    .NWR(NWR), .WIDTH(WIDTH), .ABITS(ABITS), .WORDS(WORDS), .PW(PW), .PRIO(WR_PRIO)
  ) u_arb (
    .wr_addr (wr_addr),
    .wr_mask (wr_en),
    .eff_mask(wr_eff)
  );

  regmem_store #(
    .WORDS(WORDS), .ABITS(ABITS), .WIDTH(WIDTH), .NRD(NRD), .NWR(NWR), .INIT(INIT)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .eff_mask(wr_eff),
    .rd_addr (rd_addr),
    .rd_now  (rd_raw),
    .rd_next (rd_fwd)
  );

  for (genvar i = 0; i < NRD; i++) begin : g_rport
    regmem_rd_port #(
      .WIDTH(WIDTH), .CLKED(RD_CLKED[i]), .RISE(RD_POSEDGE[i]), .TRANSP(RD_TRANSP[i])
    ) u_rp (
      .clk      (clk),
      .rst      (rst),
      .en       (rd_en[i]),
      .word_now (rd_raw[i*WIDTH +: WIDTH]),
      .word_next(rd_fwd[i*WIDTH +: WIDTH]),
      .data     (rd_data[i*WIDTH +: WIDTH])
    );
  end

endmodule

// File: rtl/regmem_props.sv
module regmem_props #(
  parameter int unsigned WORDS = 6,
  parameter int unsigned ABITS = 3,
  parameter int unsigned WIDTH = 4,
  parameter int unsigned NRD   = 4,
  parameter logic [NRD-1:0] RD_CLKED   = '0,
  parameter logic [NRD-1:0] RD_POSEDGE = '0,
  parameter logic [NRD-1:0] RD_TRANSP  = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NRD-1:0]       rd_en,
  input logic [NRD*ABITS-1:0] rd_addr,
  input logic [NRD*WIDTH-1:0] rd_data,
  input logic [NRD*WIDTH-1:0] rd_raw
);

  for (genvar i = 0; i < NRD; i++) begin : g_chk
    if (RD_CLKED[i] && RD_POSEDGE[i]) begin : g_rise
      // R1: reset clears a rising-edge port
      a_r1_rise_clear: assert property (@(posedge clk)
        rst |=> (rd_data[i*WIDTH +: WIDTH] == '0));
      // R4: no capture without enable
      a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en[i] |=> $stable(rd_data[i*WIDTH +: WIDTH]));
      if (!RD_TRANSP[i]) begin : g_old
        // R5: non-transparent port returns the word stored before the edge
        a_r5_old_word: assert property (@(posedge clk) disable iff (rst)
          rd_en[i] |=> (rd_data[i*WIDTH +: WIDTH] == $past(rd_raw[i*WIDTH +: WIDTH])));
      end
    end
    if (!RD_CLKED[i]) begin : g_async
      // R8: out-of-range address reads as zero
      a_r8_oob_zero: assert property (@(posedge clk) disable iff (rst)
        (32'(rd_addr[i*ABITS +: ABITS]) >= WORDS) |-> (rd_data[i*WIDTH +: WIDTH] == '0));
    end
  end

endmodule

bind regmem_multiport regmem_props #(
  .WORDS(WORDS), .ABITS(ABITS), .WIDTH(WIDTH), .NRD(NRD),
  .RD_CLKED(RD_CLKED), .RD_POSEDGE(RD_POSEDGE), .RD_TRANSP(RD_TRANSP)
) u_props (
  .clk    (clk),
  .rst    (rst),
  .rd_en  (rd_en),
  .rd_addr(rd_addr),
  .rd_data(rd_data),
  .rd_raw (rd_raw)
);

// File: tb/sim_regmem_multiport.sv
module sim_regmem_multiport;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 6;
  localparam int AB = 3;
  localparam int W = 4;
  localparam int NR = 4;
  localparam int NW = 3;
  localparam int PRIO [NW] = '{2, 1, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NR-1:0]    rd_en = '0;
  logic [NR*AB-1:0] rd_addr = '0;
  logic [NR*W-1:0]  rd_data;
  logic [NW*W-1:0]  wr_en = '0;
  logic [NW*AB-1:0] wr_addr = '0;
  logic [NW*W-1:0]  wr_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regmem_multiport u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0;
  int fails = 0;
  logic [W-1:0] mem_m [WORDS];
  logic [W-1:0] exp_q [NR];
  string pend_tag = "R1";
  logic [31:0] seed = 32'h1234_5678;

  logic [NR-1:0]    n_rd_en;
  logic [NR*AB-1:0] n_rd_addr;
  logic [NW*W-1:0]  n_wr_en;
  logic [NW*AB-1:0] n_wr_addr;
  logic [NW*W-1:0]  n_wr_data;

  function automatic logic [W-1:0] init_word(int k);
    return 4'(k + 9);
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < WORDS; k++) mem_m[k] = init_word(k);
    for (int i = 0; i < NR; i++) exp_q[i] = '0;
  endtask

  task automatic clear_next();
    n_rd_en = '0; n_rd_addr = '0; n_wr_en = '0; n_wr_addr = '0; n_wr_data = '0;
  endtask

  // One cycle: check last captures, drive, check combinational port, advance model.
  task automatic step(string tag);
    logic [W-1:0] new_m [WORDS];
    int a;
    @(posedge clk); #1;
    chk(pend_tag, "port1 rising transparent", rd_data[1*W +: W], exp_q[1]);
    chk(pend_tag, "port2 rising old-data",    rd_data[2*W +: W], exp_q[2]);
    chk(pend_tag, "port3 falling edge",       rd_data[3*W +: W], exp_q[3]);
    rd_en = n_rd_en; rd_addr = n_rd_addr;
    wr_en = n_wr_en; wr_addr = n_wr_addr; wr_data = n_wr_data;
    #2;
    a = int'(n_rd_addr[0 +: AB]);
    if (a >= WORDS) chk("R8", "port0 out of range", rd_data[0 +: W], '0);
    else            chk(tag, "port0 combinational", rd_data[0 +: W], mem_m[a]);
    for (int k = 0; k < WORDS; k++) begin
      new_m[k] = mem_m[k];
      for (int b = 0; b < W; b++) begin
        int best = -1;
        for (int p = 0; p < NW; p++)
          if (int'(n_wr_addr[p*AB +: AB]) == k && n_wr_en[p*W + b] &&
              (best < 0 || PRIO[p] >= PRIO[best])) best = p;
        if (best >= 0) new_m[k][b] = n_wr_data[best*W + b];
      end
    end
    for (int i = 1; i < NR; i++) begin
      a = int'(n_rd_addr[i*AB +: AB]);
      if (n_rd_en[i]) begin
        if (a >= WORDS) exp_q[i] = '0;
        else            exp_q[i] = (i == 1) ? new_m[a] : mem_m[a];
      end
    end
    for (int k = 0; k < WORDS; k++) mem_m[k] = new_m[k];
    pend_tag = tag;
  endtask

  task automatic do_reset();
    clear_next();
    @(posedge clk); #1;
    rst = 1'b1;
    rd_en = '0; wr_en = '0;
    @(posedge clk); @(posedge clk); #1;
    for (int i = 1; i < NR; i++) chk("R1", "registered port during reset", rd_data[i*W +: W], '0);
    rst = 1'b0;
    model_reset();
    pend_tag = "R1";
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < 8; a++) begin
      clear_next();
      n_rd_en = 4'b1110;
      for (int i = 0; i < NR; i++) n_rd_addr[i*AB +: AB] = 3'(a);
      step(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_next();
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    for (int i = 1; i < NR; i++) chk("R1", "registered port after reset", rd_data[i*W +: W], '0);
    rst = 1'b0;

    // R2: initial contents; R8: addresses 6 and 7
    read_all("R2");

    // R6: masked write on port 0
    clear_next();
    n_wr_addr[0 +: AB] = 3'd2; n_wr_en[0 +: W] = 4'b0101; n_wr_data[0 +: W] = 4'b0000;
    step("R6");
    read_all("R6");

    // R7: three-way collision on word 3
    clear_next();
    n_wr_addr = {3'd3, 3'd3, 3'd3};
    n_wr_en   = {4'b1100, 4'b1111, 4'b0011};
    n_wr_data = {4'b1010, 4'b0101, 4'b0110};
    n_rd_en = 4'b0110; n_rd_addr[1*AB +: AB] = 3'd3; n_rd_addr[2*AB +: AB] = 3'd3;
    step("R7");
    clear_next(); n_rd_addr[0 +: AB] = 3'd3;
    step("R7");
    chk("R7", "word 3 after collision", rd_data[0 +: W], 4'b1010);

    // R5: same-address read and write, transparent vs old data
    clear_next();
    n_wr_addr[AB +: AB] = 3'd1; n_wr_en[W +: W] = 4'hF; n_wr_data[W +: W] = 4'h3;
    n_rd_en = 4'b0110; n_rd_addr[1*AB +: AB] = 3'd1; n_rd_addr[2*AB +: AB] = 3'd1;
    step("R5");
    clear_next();
    step("R5");

    // R8: writes beyond the array are ignored
    clear_next();
    n_wr_addr = {3'd7, 3'd6, 3'd6}; n_wr_en = '1; n_wr_data = '0;
    step("R8");
    read_all("R8");

    // R9: every port on a different address at once
    clear_next();
    n_rd_en = 4'b1110; n_rd_addr = {3'd5, 3'd4, 3'd1, 3'd0};
    n_wr_addr = {3'd5, 3'd4, 3'd0}; n_wr_en = '1; n_wr_data = {4'h7, 4'h8, 4'h2};
    step("R9");
    clear_next();
    step("R9");

    // Sweep with collisions, holds and falling-edge captures
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = rnd();
      n_rd_en = r[3:0];
      n_rd_addr = r[15:4];
      for (int p = 0; p < NW; p++) begin
        logic [31:0] s;
        s = rnd();
        n_wr_addr[p*AB +: AB] = s[0] ? 3'd2 : s[3:1];
        n_wr_en[p*W +: W]     = s[7:4];
        n_wr_data[p*W +: W]   = s[11:8];
      end
      if (r[16]) n_rd_addr[1*AB +: AB] = n_wr_addr[0 +: AB];
      if (r[17]) n_rd_addr[2*AB +: AB] = n_wr_addr[0 +: AB];
      step("R3/R4/R5/R7/R9");
    end

    // R1/R2: reset mid-run restores contents and clears outputs
    do_reset();
    read_all("R2");

    clear_next();
    step("R1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule